// File: doc/BRIEF.md
# Serial Register Interface for a Precision DAC

This block is the digital front end of a voltage-output DAC. A host talks to it over a four-wire serial link: a serial clock that idles low, an active-low frame select, a data input and a data output. Data is launched on the rising clock edge and captured on the falling edge. Each transaction is a 24-bit word sent most significant bit first. Its top bit selects read (1) or write (0), the next three bits name a register, and the low 20 bits carry data. The block holds the output code, the clear code and a five-field configuration register. A write-only command address produces one-cycle request pulses for a separate update controller. That controller, together with the analog path and the hardware load, clear and reset pins, is not part of this block.

The serial pins are brought into the system clock domain through synchronisers and sampled there. The system clock must run several times faster than the serial clock. A word takes effect only if exactly 24 falling serial-clock edges occur between the fall and the rise of the frame select. When a valid read is received, the selected register is shifted out during the following frame. The data output carries no valid/ready handshake, because the link has no way to stall. The host's frame timing is the only flow control, and the readback word waits in the block until the host starts the next frame. The code width can be set to 16, 18 or 20 bits. The code is always left-aligned in the 20-bit data field.

Top module: `dac_spi_regif`

## Requirements
- R1: After reset the output code and clear code are zero, and the configuration reads amplifier-off=1, ground-clamp=1, DAC-high-impedance=1, offset-binary=0, SDO-off=0. No strobe or pulse is active.
- R2: Word layout: bit 23 = read (1) / write (0), bits 22:20 = address, bits 19:0 = data, sent MSB first and sampled on falling SCLK edges. A frame with any count other than 24 falling edges (for example 23 or 25) changes no register, raises no strobe and queues no readback.
- R3: A valid write to address 001 (output code), 010 (configuration) or 011 (clear code) updates that register. The matching write strobe is high for exactly one system-clock cycle, and the other two strobes stay low.
- R4: The output and clear codes are taken from data bits 19:(20-CODE_W). Lower data bits are ignored and read back as 0.
- R5: Configuration fields sit at data bit 5 (SDO off), bit 4 (offset-binary coding), bit 3 (DAC high impedance), bit 2 (ground clamp) and bit 1 (amplifier off). Data bits 19:6 and bit 0 are ignored and read back as 0.
- R6: A valid write to address 100 stores nothing. Data bit 0 gives a one-cycle load pulse, bit 1 a one-cycle clear pulse and bit 2 a one-cycle reset pulse, and the reset pulse also returns all registers to their R1 values. A read of 100 returns an all-zero word.
- R7: Address 000 and addresses 101 to 111 have no effect, whether the word is a read or a write, and a read of them returns an all-zero word.
- R8: After a valid read of 001, 010 or 011, whatever the data bits held, the next frame shifts out {1, address, register field}, MSB first, changing after each rising SCLK edge. The register field is the register's value at the end of the read frame. The next frame after any other frame shifts out zeros.
- R9: The SDO output enable is high only while the frame select is low and the SDO-off field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_sync_n | input | 1 | Active-low frame select |
| spi_sdin | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial readback data |
| spi_sdo_en | output | 1 | Drive enable for the SDO pad |
| dac_code | output | CODE_W | Stored output code |
| clear_code | output | CODE_W | Stored clear code |
| cfg_sdo_off | output | 1 | SDO-off field |
| cfg_offset_bin | output | 1 | Offset-binary coding select |
| cfg_dac_hiz | output | 1 | DAC high-impedance request |
| cfg_clamp_gnd | output | 1 | Output ground-clamp request |
| cfg_amp_off | output | 1 | Amplifier power-down request |
| code_wr_stb | output | 1 | Output code written |
| cfg_wr_stb | output | 1 | Configuration written |
| clear_wr_stb | output | 1 | Clear code written |
| cmd_load_pulse | output | 1 | Load request from the command address |
| cmd_clear_pulse | output | 1 | Clear request from the command address |
| cmd_reset_pulse | output | 1 | Reset request from the command address |

## Verification
The hardest thing to observe from the pins is a register's contents. They can only be seen one frame late, on SDO, and only if the previous frame was a valid read and SDO was not switched off at the start of the frame. The stimulus is therefore one unbroken chain of frames, and every frame's SDO bits are checked against the read that came before it. Random addresses and read/write choices are mixed with frames that are too short or too long, with software resets, and with configuration writes that switch SDO off. This reaches the lost-readback, zeroed-word and disabled-output cases. Directed frames around the chain set low code bits that must be dropped, and read the command address and the unused addresses.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  localparam int FRAME_W = 24;
  localparam int DATA_W  = 20;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_NOP   = 3'b000;
  localparam logic [ADDR_W-1:0] ADR_CODE  = 3'b001;
  localparam logic [ADDR_W-1:0] ADR_CFG   = 3'b010;
  localparam logic [ADDR_W-1:0] ADR_CLEAR = 3'b011;
  localparam logic [ADDR_W-1:0] ADR_CMD   = 3'b100;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  // field order matches data bits 5 down to 1
  typedef struct packed {
    logic sdo_off;
    logic offset_bin;
    logic dac_hiz;
    logic clamp_gnd;
    logic amp_off;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{sdo_off: 1'b0, offset_bin: 1'b0, dac_hiz: 1'b1,
                                 clamp_gnd: 1'b1, amp_off: 1'b1};

endpackage

// File: rtl/dsc_sync_edge.sv
module dsc_sync_edge #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[b]}};
        prev  <= RST_VAL[b];
      end else begin
        chain <= {chain[STAGES-2:0], async_in[b]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[b] = chain[STAGES-1];
    assign rise[b]  = chain[STAGES-1] & ~prev;
    assign fall[b]  = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/dsc_frame_rx.sv
module dsc_frame_rx
  import dac_spi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_low,
  input  logic   sync_rise,
  input  logic   sclk_fall,
  input  logic   sdin,
  output logic   frame_valid,
  output frame_t frame
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (sync_rise) begin
        frame_valid <= (bit_cnt == CNT_W'(FRAME_W));
      end
      if (!sync_low) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], sdin};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frame = frame_t'(shreg);

  assert_single_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

endmodule

// File: rtl/dsc_reg_bank.sv
module dsc_reg_bank
  import dac_spi_pkg::*;
#(
  parameter int CODE_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  frame_t             frame,
  output logic [CODE_W-1:0]  code_q,
  output logic [CODE_W-1:0]  clear_q,
  output cfg_t               cfg_q,
  output logic               code_stb,
  output logic               cfg_stb,
  output logic               clear_stb,
  output logic [2:0]         cmd_pulse,
  output logic               rb_valid,
  output logic [FRAME_W-1:0] rb_word
);

  localparam int PAD_W = DATA_W - CODE_W;

  logic [DATA_W-1:0] code_field;
  logic [DATA_W-1:0] clear_field;
  logic [DATA_W-1:0] cfg_field;
  logic [DATA_W-1:0] sel_field;
  logic              readable;

  if (PAD_W == 0) begin : g_full
    assign code_field  = code_q;
    assign clear_field = clear_q;
  end else begin : g_narrow
    assign code_field  = {code_q,  {PAD_W{1'b0}}};
    assign clear_field = {clear_q, {PAD_W{1'b0}}};
  end

  assign cfg_field = {{(DATA_W-6){1'b0}}, cfg_q, 1'b0};

  always_comb begin
    readable  = 1'b1;
    sel_field = '0;
    unique case (frame.addr)
      ADR_CODE:  sel_field = code_field;
      ADR_CFG:   sel_field = cfg_field;
      ADR_CLEAR: sel_field = clear_field;
      default:   readable  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      clear_q   <= '0;
      cfg_q     <= CFG_RESET;
      code_stb  <= 1'b0;
      cfg_stb   <= 1'b0;
      clear_stb <= 1'b0;
      cmd_pulse <= '0;
      rb_valid  <= 1'b0;
      rb_word   <= '0;
    end else begin
      code_stb  <= 1'b0;
      cfg_stb   <= 1'b0;
      clear_stb <= 1'b0;
      cmd_pulse <= '0;
      rb_valid  <= 1'b0;
      if (frame_valid) begin
        if (frame.rd) begin
          rb_valid <= readable;
          rb_word  <= {1'b1, frame.addr, sel_field};
        end else begin
          unique case (frame.addr)
            ADR_CODE: begin
              code_q   <= frame.data[DATA_W-1 -: CODE_W];
              code_stb <= 1'b1;
            end
            ADR_CFG: begin
              cfg_q   <= cfg_t'(frame.data[5:1]);
              cfg_stb <= 1'b1;
            end
            ADR_CLEAR: begin
              clear_q   <= frame.data[DATA_W-1 -: CODE_W];
              clear_stb <= 1'b1;
            end
            ADR_CMD: begin
              cmd_pulse <= frame.data[2:0];
              if (frame.data[2]) begin
                code_q  <= '0;
                clear_q <= '0;
                cfg_q   <= CFG_RESET;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({code_stb, cfg_stb, clear_stb}));

  assert_code_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> (code_stb || cmd_pulse[2]));

  assert_cmd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pulse) |=> !(|cmd_pulse));

  assert_nop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame.addr == ADR_NOP) |=>
      !(code_stb || cfg_stb || clear_stb || (|cmd_pulse) || rb_valid));

endmodule

// File: rtl/dsc_sdo_tx.sv
module dsc_sdo_tx
  import dac_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_low,
  input  logic               sync_fall,
  input  logic               sclk_rise,
  input  logic               rb_valid,
  input  logic [FRAME_W-1:0] rb_word,
  input  logic               sdo_off,
  output logic               sdo,
  output logic               sdo_en
);

  logic [FRAME_W-1:0] pending;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      shreg   <= '0;
      sdo     <= 1'b0;
    end else begin
      if (sync_fall) begin
        shreg   <= pending;
        pending <= '0;
      end else begin
        if (rb_valid) pending <= rb_word;
        if (sclk_rise && sync_low) begin
          sdo   <= shreg[FRAME_W-1];
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_en = sync_low & ~sdo_off;

  assert_sdo_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> $past(sclk_rise));

endmodule

// File: rtl/dac_spi_regif.sv
module dac_spi_regif
  import dac_spi_pkg::*;
#(
  parameter int CODE_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_sync_n,
  input  logic              spi_sdin,
  output logic              spi_sdo,
  output logic              spi_sdo_en,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] clear_code,
  output logic              cfg_sdo_off,
  output logic              cfg_offset_bin,
  output logic              cfg_dac_hiz,
  output logic              cfg_clamp_gnd,
  output logic              cfg_amp_off,
  output logic              code_wr_stb,
  output logic              cfg_wr_stb,
  output logic              clear_wr_stb,
  output logic              cmd_load_pulse,
  output logic              cmd_clear_pulse,
  output logic              cmd_reset_pulse
);

  localparam int PIN_SCLK = 0;
  localparam int PIN_SYNC = 1;
  localparam int PIN_SDIN = 2;

  logic [2:0]         pin_level, pin_rise, pin_fall;
  logic               frame_valid;
  frame_t             frame;
  cfg_t               cfg_q;
  logic [2:0]         cmd_pulse;
  logic               rb_valid;
  logic [FRAME_W-1:0] rb_word;
  logic               unused_edges;

  dsc_sync_edge #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_sdin, spi_sync_n, spi_sclk}),
    .level    (pin_level),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  assign unused_edges = ^{pin_level[PIN_SCLK], pin_rise[PIN_SDIN], pin_fall[PIN_SDIN]};

  dsc_frame_rx i_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_low    (~pin_level[PIN_SYNC]),
    .sync_rise   (pin_rise[PIN_SYNC]),
    .sclk_fall   (pin_fall[PIN_SCLK]),
    .sdin        (pin_level[PIN_SDIN]),
    .frame_valid (frame_valid),
    .frame       (frame)
  );

  dsc_reg_bank #(.CODE_W(CODE_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame       (frame),
    .code_q      (dac_code),
    .clear_q     (clear_code),
    .cfg_q       (cfg_q),
    .code_stb    (code_wr_stb),
    .cfg_stb     (cfg_wr_stb),
    .clear_stb   (clear_wr_stb),
    .cmd_pulse   (cmd_pulse),
    .rb_valid    (rb_valid),
    .rb_word     (rb_word)
  );

  dsc_sdo_tx i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_low  (~pin_level[PIN_SYNC]),
    .sync_fall (pin_fall[PIN_SYNC]),
    .sclk_rise (pin_rise[PIN_SCLK]),
    .rb_valid  (rb_valid),
    .rb_word   (rb_word),
    .sdo_off   (cfg_q.sdo_off),
    .sdo       (spi_sdo),
    .sdo_en    (spi_sdo_en)
  );

  assign cfg_sdo_off     = cfg_q.sdo_off;
  assign cfg_offset_bin  = cfg_q.offset_bin;
  assign cfg_dac_hiz     = cfg_q.dac_hiz;
  assign cfg_clamp_gnd   = cfg_q.clamp_gnd;
  assign cfg_amp_off     = cfg_q.amp_off;
  assign cmd_load_pulse  = cmd_pulse[0];
  assign cmd_clear_pulse = cmd_pulse[1];
  assign cmd_reset_pulse = cmd_pulse[2];

  assert_sdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sdo_off |-> !spi_sdo_en);

endmodule

// File: tb/test_dac_spi_regif.sv
`timescale 1ns/1ps
module test_dac_spi_regif;

  localparam int CW = 18;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0;
  logic sdo, sdo_en;
  logic [CW-1:0] dac_code, clear_code;
  logic c_sdo, c_bin, c_hiz, c_clamp, c_amp;
  logic s_code, s_cfg, s_clr, p_load, p_clear, p_reset;

  int n_tests = 0, n_fail = 0;
  int cnt_code, cnt_cfg, cnt_clr, cnt_load, cnt_clear, cnt_reset;
  bit en_seen;

  logic [CW-1:0]  m_code, m_clr;
  logic [4:0]     m_cfg;
  logic [23:0]    m_next_word;

  always #2 clk = ~clk;

  dac_spi_regif #(.CODE_W(CW)) i_dac_spi_regif (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sync_n(sync_n), .spi_sdin(sdin),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .dac_code(dac_code), .clear_code(clear_code),
    .cfg_sdo_off(c_sdo), .cfg_offset_bin(c_bin), .cfg_dac_hiz(c_hiz),
    .cfg_clamp_gnd(c_clamp), .cfg_amp_off(c_amp), .code_wr_stb(s_code),
    .cfg_wr_stb(s_cfg), .clear_wr_stb(s_clr), .cmd_load_pulse(p_load),
    .cmd_clear_pulse(p_clear), .cmd_reset_pulse(p_reset)
  );

  always @(negedge clk) begin
    cnt_code  <= cnt_code  + int'(s_code);
    cnt_cfg   <= cnt_cfg   + int'(s_cfg);
    cnt_clr   <= cnt_clr   + int'(s_clr);
    cnt_load  <= cnt_load  + int'(p_load);
    cnt_clear <= cnt_clear + int'(p_clear);
    cnt_reset <= cnt_reset + int'(p_reset);
    if (sdo_en) en_seen <= 1'b1;
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] rb_expect(input logic [2:0] a);
    case (a)
      3'd1:    return {1'b1, a, m_code, {(20-CW){1'b0}}};
      3'd2:    return {1'b1, a, 14'd0, m_cfg, 1'b0};
      3'd3:    return {1'b1, a, m_clr, {(20-CW){1'b0}}};
      default: return 24'd0;
    endcase
  endfunction

  task automatic do_frame(input logic [23:0] f, input int nbits);
    logic [23:0] got;
    logic [23:0] exp_word;
    logic        exp_en;
    logic        valid, wr;
    logic [2:0]  a;
    logic [19:0] d;
    string       tag;
    int          e_code, e_cfg, e_clr;
    logic [2:0]  e_cmd;
    got = '0;
    exp_en   = !m_cfg[4];
    exp_word = m_next_word;
    @(negedge clk);
    cnt_code = 0; cnt_cfg = 0; cnt_clr = 0;
    cnt_load = 0; cnt_clear = 0; cnt_reset = 0; en_seen = 0;
    tick(1);
    sync_n = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? f[23-i] : 1'b0;
      sclk = 1'b1;
      tick(H);
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b0;
      tick(H);
    end
    sync_n = 1'b1;
    tick(12);

    valid = (nbits == 24);
    wr = valid && !f[23];
    a  = f[22:20];
    d  = f[19:0];
    check("R9 sdo enable", {23'd0, en_seen}, {23'd0, exp_en});
    if (exp_en) check("R8 readback word", got, exp_word);

    m_next_word = (valid && f[23]) ? rb_expect(a) : 24'd0;
    e_code = 0; e_cfg = 0; e_clr = 0; e_cmd = 3'b000;
    if (wr) begin
      case (a)
        3'd1: begin m_code = d[19 -: CW]; e_code = 1; end
        3'd2: begin m_cfg = d[5:1]; e_cfg = 1; end
        3'd3: begin m_clr = d[19 -: CW]; e_clr = 1; end
        3'd4: begin
          e_cmd = d[2:0];
          if (d[2]) begin m_code = '0; m_clr = '0; m_cfg = 5'b00111; end
        end
        default: ;
      endcase
    end
    if (!valid) tag = "R2";
    else if (a == 3'd0 || a > 3'd4) tag = "R7";
    else if (a == 3'd4) tag = "R6";
    else if (a == 3'd2) tag = "R5";
    else tag = "R4";
    check({tag, " code"},  {6'd0, dac_code},  {6'd0, m_code});
    check({tag, " clear"}, {6'd0, clear_code}, {6'd0, m_clr});
    check({tag, " cfg"}, {19'd0, c_sdo, c_bin, c_hiz, c_clamp, c_amp}, {19'd0, m_cfg});
    check("R3 strobe counts", {cnt_code[7:0], cnt_cfg[7:0], cnt_clr[7:0]},
          {e_code[7:0], e_cfg[7:0], e_clr[7:0]});
    check("R6 cmd pulse counts", {cnt_load[7:0], cnt_clear[7:0], cnt_reset[7:0]},
          {7'd0, e_cmd[0], 7'd0, e_cmd[1], 7'd0, e_cmd[2]});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    m_code = '0; m_clr = '0; m_cfg = 5'b00111; m_next_word = '0;
    cnt_code = 0; cnt_cfg = 0; cnt_clr = 0;
    cnt_load = 0; cnt_clear = 0; cnt_reset = 0; en_seen = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    check("R1 code", {6'd0, dac_code}, 24'd0);
    check("R1 clear", {6'd0, clear_code}, 24'd0);
    check("R1 cfg", {19'd0, c_sdo, c_bin, c_hiz, c_clamp, c_amp}, 24'h7);
    check("R1 strobes", {18'd0, s_code, s_cfg, s_clr, p_load, p_clear, p_reset}, 24'd0);

    // directed corners
    do_frame(24'h2_00012, 24);           // R5 cfg write
    do_frame(24'h1_8000F, 24);           // R4 low bits ignored
    do_frame(24'h9_00000, 24);           // read code
    do_frame(24'h0_00000, 24);           // R8 readback of code
    do_frame(24'h3_FFFFF, 24);           // clear full scale
    do_frame(24'hB_12345, 24);           // read clear, data don't care
    do_frame(24'h1_23456, 23);           // R2 short frame loses readback
    do_frame(24'h1_23456, 25);           // R2 long frame
    do_frame(24'hA_00000, 24);           // read cfg
    do_frame(24'hC_00000, 24);           // R6 read of cmd -> zeros next
    do_frame(24'hF_00000, 24);           // R7 read unused
    do_frame(24'h8_00000, 24);           // R7 read nop
    do_frame(24'h4_00003, 24);           // R6 load + clear pulses
    do_frame(24'h2_00020, 24);           // R9 sdo off
    do_frame(24'hB_00000, 24);           // read while off
    do_frame(24'h4_00004, 24);           // R6 reset restores defaults
    do_frame(24'hA_00000, 24);
    do_frame(24'h0_00000, 24);

    for (int k = 0; k < 150; k++) begin
      logic [23:0] f;
      int r;
      f = $urandom;
      f[23] = ($urandom % 4 == 0);
      if (f[22:20] == 3'd2) f[5] = ($urandom % 4 == 0);
      if (f[22:20] == 3'd4) f[2] = ($urandom % 6 == 0);
      r = $urandom % 10;
      do_frame(f, (r == 0) ? 23 : (r == 1) ? 25 : 24);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule